// File: doc/BRIEF.md
# Serial Control Port Command Decoder

This block sits behind the byte shifter of a chip-select-framed control port and decides what each received byte means. The first byte after chip-select falls is a command. Bit 7 gives the direction, bits 6:5 give the register class and bits 4:0 give an address. The decoder keeps a small global register file and a local register file for each channel. It serves global and local reads and writes itself. Coefficient-RAM commands are passed to a separate burst engine. Every read answer goes out through a request/acknowledge byte handshake and starts with a fixed identification byte.

One global register holds the channel-enable bits. These choose the channels that local accesses touch. Local accesses always move a register pair: the high register first, then the low one. Writes go to every enabled channel. Reads come from the lowest-numbered enabled channel. Raising chip-select at any point returns the decoder to waiting for a command.

Top module: `ctlp_cmd_decoder`

## Requirements
- R1: After reset, `tx_req`, `ram_go` and `ch_en` are 0 and every register reads as 0x00.
- R2: A command with bits 6:5 = 01 and bit 7 = 1 writes the next byte into global register bits 4:0. The same command with bit 7 = 0 reads it back as the identification byte 0x81 followed by the stored byte.
- R3: Global address 5 is the channel-enable register. Its bit i enables channel i, and `ch_en` shows the new value in the cycle after its data byte is received.
- R4: A command with bits 6:5 = 00 and bit 7 = 1 writes the next two bytes to local pair bits 4:0, high register first, in every enabled channel. A read (bit 7 = 0) returns 0x81, high, low from the lowest-numbered enabled channel.
- R5: A read response raises `tx_req` in the cycle after the command byte, with 0x81 as the first byte. Each byte stays on `tx_byte` until `tx_ack` is seen, and `tx_req` falls after the last byte is acknowledged.
- R6: Reads of unimplemented addresses return 0x00 data after 0x81. These are global addresses at or above 8, local pairs at or above 4, and class 10, which answers like a global read. Writes to those addresses change no register.
- R7: A command with bits 6:5 = 11 pulses `ram_go` for exactly one cycle, in the cycle after the command byte. During that pulse `ram_write` is bit 7 and `ram_blk` is bits 4:0. All later bytes are ignored until chip-select rises.
- R8: `cs_n` high returns the decoder to waiting for a command. It cancels a pending data byte or response, and the next byte after chip-select falls is taken as a command. Bytes already written stay written.
- R9: Bytes received while a read response is pending are ignored.
- R10: With no channel enabled, a local write changes nothing and a local read returns 0x81, 0x00, 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip-select, active low; high ends the transaction |
| rx_valid | input | 1 | One-cycle strobe: `rx_byte` holds a new byte |
| rx_byte | input | 8 | Received byte |
| tx_ack | input | 1 | Shifter has taken `tx_byte` |
| tx_req | output | 1 | A response byte is waiting on `tx_byte` |
| tx_byte | output | 8 | Response byte |
| ch_en | output | NUM_CH | Channel-enable bits |
| ram_go | output | 1 | One-cycle start for the RAM burst engine |
| ram_write | output | 1 | Direction of the RAM burst (1 = write) |
| ram_blk | output | 5 | Block address for the RAM burst |

## Verification
Every result is registered once. `tx_req` with the identification byte, `ram_go` with its fields, and a new `ch_en` value all appear in the cycle after the byte that causes them. Each following response byte appears in the cycle after the acknowledge of the one before. The bench drives bytes for one cycle from a falling edge. It samples on the next falling edge, half a cycle after the capturing edge, and then pulses `tx_ack` one byte at a time. That lets each check land in the exact cycle a result is due, and a check made several cycles later confirms that a held value has not moved.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    typedef enum logic [2:0] {
        ST_CMD   = 3'd0,
        ST_GDATA = 3'd1,
        ST_LHI   = 3'd2,
        ST_LLO   = 3'd3,
        ST_RESP  = 3'd4,
        ST_RAM   = 3'd5
    } st_e;

    typedef enum logic [1:0] {
        CL_LOCAL  = 2'b00,
        CL_GLOBAL = 2'b01,
        CL_SPARE  = 2'b10,
        CL_RAM    = 2'b11
    } cls_e;

    typedef struct packed {
        logic       is_wr;
        cls_e       cls;
        logic [4:0] addr;
    } cmd_t;

    localparam logic [7:0] ID_BYTE = 8'h81;

endpackage

// File: rtl/ctlp_cmd_classify.sv
module ctlp_cmd_classify
    import ctlp_pkg::*;
#(
    parameter int NUM_GREG  = 8,
    parameter int NUM_LPAIR = 4
) (
    input  logic [7:0] byte_i,
    output cmd_t       cmd_o,
    output logic       g_hit_o,
    output logic       l_hit_o
);
    always_comb begin
        cmd_o.is_wr = byte_i[7];
        cmd_o.cls   = cls_e'(byte_i[6:5]);
        cmd_o.addr  = byte_i[4:0];
        g_hit_o     = (32'(byte_i[4:0]) < NUM_GREG);
        l_hit_o     = (32'(byte_i[4:0]) < NUM_LPAIR);
    end
endmodule

// File: rtl/ctlp_chan_pick.sv
module ctlp_chan_pick #(
    parameter int NUM_CH = 4,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] en_i,
    output logic [CHW-1:0]    sel_o,
    output logic              any_o
);
    always_comb begin
        sel_o = '0;
        any_o = 1'b0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (en_i[c]) begin
                sel_o = CHW'(c);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctlp_local_bank.sv
module ctlp_local_bank #(
    parameter int PAIRS = 4,
    localparam int PW   = (PAIRS > 1) ? $clog2(PAIRS) : 1,
    localparam int NREG = 2 * PAIRS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_hi,
    input  logic [PW-1:0] wr_pair,
    input  logic [7:0]    wr_data,
    input  logic [PW-1:0] rd_pair,
    output logic [7:0]    rd_hi,
    output logic [7:0]    rd_lo
);
    logic [NREG-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[{wr_pair, wr_hi}] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_hi = mem_q[{rd_pair, 1'b1}];
    assign rd_lo = mem_q[{rd_pair, 1'b0}];
endmodule

// File: rtl/ctlp_cmd_decoder.sv
module ctlp_cmd_decoder
    import ctlp_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_GREG  = 8,
    parameter int NUM_LPAIR = 4,
    parameter int CHEN_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_ack,
    output logic              tx_req,
    output logic [7:0]        tx_byte,
    output logic [NUM_CH-1:0] ch_en,
    output logic              ram_go,
    output logic              ram_write,
    output logic [4:0]        ram_blk
);
    localparam int GW  = (NUM_GREG > 1) ? $clog2(NUM_GREG) : 1;
    localparam int LPW = (NUM_LPAIR > 1) ? $clog2(NUM_LPAIR) : 1;
    localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        st_e                        st;
        logic [4:0]                 addr;
        logic                       wr_ok;
        logic [2:0][7:0]            resp;
        logic [1:0]                 rlast;
        logic [1:0]                 ridx;
        logic [NUM_GREG-1:0][7:0]   greg;
        logic                       ram_go;
        logic                       ram_wr;
        logic [4:0]                 ram_blk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    cmd_t              cmd;
    logic              g_hit, l_hit;
    logic              take;
    logic              lwr_en, lwr_hi;
    logic [CHW-1:0]    rd_sel;
    logic              rd_any;
    logic [NUM_CH-1:0][7:0] bank_hi, bank_lo;

    ctlp_cmd_classify #(.NUM_GREG(NUM_GREG), .NUM_LPAIR(NUM_LPAIR)) u_cls (
        .byte_i (rx_byte),
        .cmd_o  (cmd),
        .g_hit_o(g_hit),
        .l_hit_o(l_hit)
    );

    ctlp_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
        .en_i (ch_en),
        .sel_o(rd_sel),
        .any_o(rd_any)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        ctlp_local_bank #(.PAIRS(NUM_LPAIR)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (lwr_en & ch_en[c]),
            .wr_hi  (lwr_hi),
            .wr_pair(ctl_q.addr[LPW-1:0]),
            .wr_data(rx_byte),
            .rd_pair(cmd.addr[LPW-1:0]),
            .rd_hi  (bank_hi[c]),
            .rd_lo  (bank_lo[c])
        );
    end

    assign take = rx_valid & ~cs_n;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.ram_go = 1'b0;
        lwr_en       = 1'b0;
        lwr_hi       = 1'b0;
        if (cs_n) begin
            ctl_d.st = ST_CMD;
        end else begin
            unique case (ctl_q.st)
                ST_CMD: if (take) begin
                    ctl_d.addr = cmd.addr;
                    ctl_d.ridx = 2'd0;
                    ctl_d.resp = '0;
                    ctl_d.resp[0] = ID_BYTE;
                    unique case (cmd.cls)
                        CL_RAM: begin
                            ctl_d.st      = ST_RAM;
                            ctl_d.ram_go  = 1'b1;
                            ctl_d.ram_wr  = cmd.is_wr;
                            ctl_d.ram_blk = cmd.addr;
                        end
                        CL_LOCAL: begin
                            ctl_d.wr_ok = l_hit;
                            if (cmd.is_wr) begin
                                ctl_d.st = ST_LHI;
                            end else begin
                                ctl_d.st    = ST_RESP;
                                ctl_d.rlast = 2'd2;
                                if (l_hit && rd_any) begin
                                    ctl_d.resp[1] = bank_hi[rd_sel];
                                    ctl_d.resp[2] = bank_lo[rd_sel];
                                end
                            end
                        end
                        default: begin
                            ctl_d.wr_ok = g_hit && (cmd.cls == CL_GLOBAL);
                            if (cmd.is_wr) begin
                                ctl_d.st = ST_GDATA;
                            end else begin
                                ctl_d.st    = ST_RESP;
                                ctl_d.rlast = 2'd1;
                                if (g_hit && (cmd.cls == CL_GLOBAL)) begin
                                    ctl_d.resp[1] = ctl_q.greg[cmd.addr[GW-1:0]];
                                end
                            end
                        end
                    endcase
                end
                ST_GDATA: if (take) begin
                    if (ctl_q.wr_ok) begin
                        ctl_d.greg[ctl_q.addr[GW-1:0]] = rx_byte;
                    end
                    ctl_d.st = ST_CMD;
                end
                ST_LHI: if (take) begin
                    lwr_en   = ctl_q.wr_ok;
                    lwr_hi   = 1'b1;
                    ctl_d.st = ST_LLO;
                end
                ST_LLO: if (take) begin
                    lwr_en   = ctl_q.wr_ok;
                    ctl_d.st = ST_CMD;
                end
                ST_RESP: if (tx_ack) begin
                    if (ctl_q.ridx == ctl_q.rlast) begin
                        ctl_d.st = ST_CMD;
                    end else begin
                        ctl_d.ridx = ctl_q.ridx + 2'd1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_CMD;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign tx_req    = (ctl_q.st == ST_RESP);
    assign tx_byte   = ctl_q.resp[ctl_q.ridx];
    assign ch_en     = ctl_q.greg[CHEN_ADDR][NUM_CH-1:0];
    assign ram_go    = ctl_q.ram_go;
    assign ram_write = ctl_q.ram_wr;
    assign ram_blk   = ctl_q.ram_blk;
endmodule

// File: rtl/ctlp_cmd_decoder_chk.sv
module ctlp_cmd_decoder_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rx_valid,
    input logic [7:0]        rx_byte,
    input logic              tx_ack,
    input logic              tx_req,
    input logic [7:0]        tx_byte,
    input logic [NUM_CH-1:0] ch_en,
    input logic              ram_go
);
    p_first_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> tx_byte == 8'h81);

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !tx_ack && !cs_n) |=> (tx_req && $stable(tx_byte)));

    p_ram_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_go |=> !ram_go);

    p_ram_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_go) |-> $past(rx_valid && !cs_n && rx_byte[6:5] == 2'b11));

    p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!tx_req && !ram_go));

    p_chen_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_en) |-> $past(rx_valid && !cs_n));
endmodule

bind ctlp_cmd_decoder ctlp_cmd_decoder_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rx_valid(rx_valid),
    .rx_byte (rx_byte),
    .tx_ack  (tx_ack),
    .tx_req  (tx_req),
    .tx_byte (tx_byte),
    .ch_en   (ch_en),
    .ram_go  (ram_go)
);

// File: tb/test_ctlp_cmd_decoder.sv
module test_ctlp_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_ack = 1'b0;
    logic       tx_req;
    logic [7:0] tx_byte;
    logic [3:0] ch_en;
    logic       ram_go, ram_write;
    logic [4:0] ram_blk;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    ctlp_cmd_decoder i_ctlp_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_ack(tx_ack), .tx_req(tx_req), .tx_byte(tx_byte),
        .ch_en(ch_en), .ram_go(ram_go), .ram_write(ram_write), .ram_blk(ram_blk)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic cs_pulse();
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic get_resp(input string req, input int n,
                            input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] exp [3];
        exp[0] = 8'h81; exp[1] = b1; exp[2] = b2;
        for (int i = 0; i <= n; i++) begin
            chk(req, "tx_req", 32'(tx_req), 32'd1);
            chk(req, "tx_byte", 32'(tx_byte), 32'(exp[i]));
            tx_ack = 1'b1;
            @(negedge clk);
            tx_ack = 1'b0;
        end
        chk(req, "tx_req end", 32'(tx_req), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1", "tx_req", 32'(tx_req), 0);
        chk("R1", "ch_en", 32'(ch_en), 0);
        chk("R1", "ram_go", 32'(ram_go), 0);
        send(8'h23); get_resp("R1", 1, 8'h00, 8'h00);
    endtask

    task automatic t_global();
        send(8'hA2); send(8'hA5);
        send(8'h22);
        repeat (3) @(negedge clk);
        chk("R5", "held tx_req", 32'(tx_req), 1);
        chk("R5", "held id", 32'(tx_byte), 32'h81);
        get_resp("R2", 1, 8'hA5, 8'h00);
        send(8'hA0); send(8'hFF);
        send(8'h20); get_resp("R2", 1, 8'hFF, 8'h00);
    endtask

    task automatic t_chen();
        send(8'hA5); send(8'h05);
        chk("R3", "ch_en", 32'(ch_en), 32'h5);
    endtask

    task automatic t_local();
        send(8'h81); send(8'h12); send(8'h34);
        send(8'hA5); send(8'h04);
        send(8'h01); get_resp("R4", 2, 8'h12, 8'h34);
        send(8'hA5); send(8'h02);
        send(8'h01); get_resp("R4", 2, 8'h00, 8'h00);
        send(8'hA5); send(8'h07);
        send(8'h01); get_resp("R4", 2, 8'h12, 8'h34);
    endtask

    task automatic t_unimpl();
        send(8'h3F); get_resp("R6", 1, 8'h00, 8'h00);
        send(8'hBF); send(8'h77);
        send(8'h3F); get_resp("R6", 1, 8'h00, 8'h00);
        send(8'h10); get_resp("R6", 2, 8'h00, 8'h00);
        send(8'h40); get_resp("R6", 1, 8'h00, 8'h00);
        send(8'hC2); send(8'h99);
        send(8'h22); get_resp("R6", 1, 8'hA5, 8'h00);
    endtask

    task automatic t_ram();
        send(8'hE2);
        chk("R7", "ram_go", 32'(ram_go), 1);
        chk("R7", "ram_write", 32'(ram_write), 1);
        chk("R7", "ram_blk", 32'(ram_blk), 2);
        @(negedge clk);
        chk("R7", "ram_go drop", 32'(ram_go), 0);
        send(8'hA0); send(8'h33);
        send(8'h20);
        chk("R7", "no resp", 32'(tx_req), 0);
        cs_pulse();
        send(8'h20); get_resp("R7", 1, 8'hFF, 8'h00);
        send(8'h63);
        chk("R7", "rd ram_go", 32'(ram_go), 1);
        chk("R7", "rd ram_write", 32'(ram_write), 0);
        chk("R7", "rd ram_blk", 32'(ram_blk), 3);
        cs_pulse();
    endtask

    task automatic t_cs_abort();
        send(8'hA2); cs_pulse();
        send(8'h22); get_resp("R8", 1, 8'hA5, 8'h00);
        send(8'hA5); send(8'h01);
        send(8'h80); send(8'hAA); cs_pulse();
        send(8'h00); get_resp("R8", 2, 8'hAA, 8'h00);
        send(8'h22);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        chk("R8", "resp cancelled", 32'(tx_req), 0);
        cs_n = 1'b0;
    endtask

    task automatic t_busy();
        send(8'h22);
        send(8'hA2); send(8'h00);
        get_resp("R9", 1, 8'hA5, 8'h00);
        send(8'h22); get_resp("R9", 1, 8'hA5, 8'h00);
    endtask

    task automatic t_nochan();
        send(8'hA5); send(8'h00);
        chk("R10", "ch_en", 32'(ch_en), 0);
        send(8'h80); send(8'h55); send(8'h66);
        send(8'h00); get_resp("R10", 2, 8'h00, 8'h00);
        send(8'hA5); send(8'h01);
        send(8'h00); get_resp("R10", 2, 8'hAA, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global();
        t_chen();
        t_local();
        t_unimpl();
        t_ram();
        t_cs_abort();
        t_busy();
        t_nochan();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule